// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide programming port of an eight-line interrupt controller. Software writes to two addresses. Address 0 carries the start-of-setup word and the operation commands. Address 1 carries the remaining setup words and, once setup is done, the line mask. The block keeps several pieces of state: the mask, the vector base, the mode flags, the rotating priority offset, and the in-service register. It also serves register reads and a polled acknowledge.

Request latching and the search for the winning pending line sit outside this block. A neighbouring block presents the request register (`irqReq`) and the winner (`pendValid`, `pendLine`). This block uses them when software reads registers, polls, or runs a processor acknowledge cycle (`intAck`). On each acknowledge it reports the line it took (`ackValid`, `ackLine`), so that the request latch can retire that line.

Bus accesses are one-cycle strobes. Writes take effect at the rising clock edge of the strobe cycle. Read data and the acknowledge vector are combinational during the strobe, and their side effects land at that same edge. At most one of a write, a read or an acknowledge is active in any cycle.

Top module: `irq_cmd_decoder`

## Requirements
- R1: After reset the mask, the in-service register and the priority offset are zero. All mode flags are clear. The block is in normal mode, so an address-1 write loads the mask.
- R2: An address-0 write with bit 4 set starts setup. It clears the mask, the in-service register, the offset, the vector base, the nested flag, the auto-EOI flag, the rotate-on-auto-EOI flag, the special-mask flag, the read select and the poll arm. It records bit 0 as "fourth word follows" and bit 1 as "single controller".
- R3: The next address-1 write sets the vector base to the data AND 0xF8. If the single flag is clear, the next word is the third word, whose data is discarded. If the single flag is set, the third word is skipped. After the second or third word, the fourth word follows if its flag is set; otherwise the block returns to normal mode.
- R4: The fourth word sets the nested flag (`nestedMode`) from bit 4 and the auto-EOI flag (`autoEoiMode`) from bit 1. The block then returns to normal mode, where address-1 writes load the mask.
- R5: An address-0 write with bit 4 clear and bit 3 set is a read/poll command:
  - bit 2 set arms poll;
  - bit 1 set makes bit 0 the read select (1 = in-service, 0 = request);
  - bit 6 set makes bit 5 the new special-mask flag.
- R6: With poll not armed, a read of address 0 returns the in-service register or `irqReq`, as the read select chooses. A read of address 1 returns the mask.
- R7: During `intAck` with a pending line, `vecOut` is the base plus the line and `ackValid` is high with `ackLine` equal to the line. With auto-EOI off, the line's in-service bit is set at the edge.
- R8: During `intAck` with no pending line, `vecOut` is the base plus 7 and no state changes.
- R9: With auto-EOI on, an acknowledge sets no in-service bit. If the rotate-on-auto-EOI flag is set, the offset becomes line+1 mod 8. That flag is written by command codes 0 and 4 (data bits 7:5 = 000 or 100), with data bit 7 as its new value.
- R10: Code 1 clears the in-service bit that wins the rotated search, scanning lines offset, offset+1, … mod 8. Code 5 does the same and also sets the offset to that line+1. With no in-service bit set, neither code has any effect.
- R11: Code 3 clears in-service bit (data & 7). Code 7 clears it and also sets the offset to (data & 7)+1 mod 8.
- R12: Code 6 sets the offset to ((data & 7)+1) mod 8. Code 2 changes nothing.
- R13: A read while poll is armed acknowledges the pending line and returns 0x80 OR that line, or returns 0 when nothing is pending. Poll is disarmed afterwards, so the next read returns a register again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Bus select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while cs and rd are high |
| irqReq | input | 8 | Request register from the trigger latch |
| pendValid | input | 1 | A line wins the priority search |
| pendLine | input | 3 | Winning line number |
| intAck | input | 1 | Processor acknowledge cycle |
| vecOut | output | 8 | Vector for the acknowledge cycle |
| ackValid | output | 1 | A line is being acknowledged this cycle |
| ackLine | output | 3 | Line being acknowledged |
| maskOut | output | 8 | Mask register |
| isrOut | output | 8 | In-service register |
| prioOffset | output | 3 | Priority rotation offset |
| nestedMode | output | 1 | Special fully nested flag |
| autoEoiMode | output | 1 | Auto end-of-interrupt flag |
| specialMask | output | 1 | Special mask flag |

## Verification
The cycle-level assertions cover the following:
- setup entry lands in the second-word state and clears the mask and in-service register;
- mask loads track the written byte;
- an acknowledge sets the line's in-service bit, or leaves the register untouched under auto-EOI;
- a spurious acknowledge changes nothing;
- a specific EOI clears the named bit;
- a poll read always disarms poll.

Only the bench's scenarios can show the rest:
- the word-skipping paths through setup, including the discarded third word;
- the vector arithmetic;
- the rotated search that picks which bit a non-specific EOI clears;
- the offset values produced by the rotate commands and by auto-EOI rotation.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;
  localparam int LINES = 8;
  localparam int LINE_W = $clog2(LINES);
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ST_NORMAL,
    ST_WORD2,
    ST_WORD3,
    ST_WORD4
  } init_state_e;

  // Strobes from the control to the datapath; at most one access per cycle.
  typedef struct packed {
    logic startInit;
    logic loadBase;
    logic loadMode;
    logic loadMask;
    logic setSel;
    logic setSmm;
    logic setRotAeoi;
    logic eoiTop;
    logic eoiLine;
    logic rotate;
    logic setOff;
    logic ackReq;
    logic pollRead;
  } strobe_t;
endpackage

// File: rtl/irq_cmd_ctrl.sv
module irq_cmd_ctrl
  import irq_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              intAck,
  output strobe_t           st,
  output logic              pollArmed
);
  init_state_e initState, stateNext;
  logic needWord4, singleCtl;
  logic wrCmd, wrData, armPoll;

  assign wrCmd  = cs & wr & ~addr;
  assign wrData = cs & wr & addr;

  always_comb begin
    st = '0;
    armPoll = 1'b0;
    stateNext = initState;
    if (wrCmd) begin
      if (wdata[4]) begin
        st.startInit = 1'b1;
        stateNext = ST_WORD2;
      end else if (wdata[3]) begin
        armPoll  = wdata[2];
        st.setSel = wdata[1];
        st.setSmm = wdata[6];
      end else begin
        unique case (wdata[7:5])
          3'd0, 3'd4: st.setRotAeoi = 1'b1;
          3'd1: st.eoiTop = 1'b1;
          3'd5: begin st.eoiTop = 1'b1; st.rotate = 1'b1; end
          3'd3: st.eoiLine = 1'b1;
          3'd7: begin st.eoiLine = 1'b1; st.rotate = 1'b1; end
          3'd6: st.setOff = 1'b1;
          default: ;
        endcase
      end
    end else if (wrData) begin
      unique case (initState)
        ST_NORMAL: st.loadMask = 1'b1;
        ST_WORD2: begin
          st.loadBase = 1'b1;
          if (!singleCtl)     stateNext = ST_WORD3;
          else if (needWord4) stateNext = ST_WORD4;
          else                stateNext = ST_NORMAL;
        end
        ST_WORD3: stateNext = needWord4 ? ST_WORD4 : ST_NORMAL;
        ST_WORD4: begin
          st.loadMode = 1'b1;
          stateNext = ST_NORMAL;
        end
        default: stateNext = ST_NORMAL;
      endcase
    end
    st.pollRead = cs & rd & ~wr & pollArmed;
    st.ackReq   = intAck | st.pollRead;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      initState <= ST_NORMAL;
      needWord4 <= 1'b0;
      singleCtl <= 1'b0;
      pollArmed <= 1'b0;
    end else begin
      initState <= stateNext;
      if (st.startInit) begin
        needWord4 <= wdata[0];
        singleCtl <= wdata[1];
        pollArmed <= 1'b0;
      end else if (armPoll) begin
        pollArmed <= 1'b1;
      end else if (st.pollRead) begin
        pollArmed <= 1'b0;
      end
    end
  end

  // R3: setup always waits for the second word after a start word
  a_r3_init_waits: assert property (@(posedge clk) disable iff (!rst_n)
    st.startInit |=> initState == ST_WORD2);
  // R13: a poll read leaves poll disarmed
  a_r13_poll_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    st.pollRead |=> !pollArmed);
endmodule

// File: rtl/irq_cmd_dpath.sv
module irq_cmd_dpath
  import irq_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           st,
  input  logic              pollArmed,
  input  logic              cs,
  input  logic              rd,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LINES-1:0]  irqReq,
  input  logic              pendValid,
  input  logic [LINE_W-1:0] pendLine,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] vecOut,
  output logic              ackValid,
  output logic [LINE_W-1:0] ackLine,
  output logic [LINES-1:0]  maskOut,
  output logic [LINES-1:0]  isrOut,
  output logic [LINE_W-1:0] prioOffset,
  output logic              nestedMode,
  output logic              autoEoiMode,
  output logic              specialMask
);
  localparam logic [DATA_W-1:0] BASE_MASK = ~DATA_W'(LINES - 1);

  logic [LINES-1:0]  maskReg, isrReg, isrNext;
  logic [DATA_W-1:0] baseReg;
  logic [LINE_W-1:0] offReg, offNext;
  logic nestedReg, aeoiReg, rotAeoiReg, regSelReg, smmReg;
  logic ackTake, topValid;
  logic [LINE_W-1:0] topLine, cmdLine;

  assign ackTake = st.ackReq & pendValid;
  assign cmdLine = wdata[LINE_W-1:0];

  // Rotated search over the in-service register; lowest distance from the offset wins.
  always_comb begin
    logic [LINE_W-1:0] idx;
    topValid = 1'b0;
    topLine  = '0;
    idx      = '0;
    for (int p = LINES - 1; p >= 0; p--) begin
      idx = offReg + LINE_W'(p);
      if (isrReg[idx]) begin
        topValid = 1'b1;
        topLine  = idx;
      end
    end
  end

  always_comb begin
    isrNext = isrReg;
    offNext = offReg;
    if (st.eoiTop && topValid) begin
      isrNext[topLine] = 1'b0;
      if (st.rotate) offNext = topLine + 1'b1;
    end
    if (st.eoiLine) begin
      isrNext[cmdLine] = 1'b0;
      if (st.rotate) offNext = cmdLine + 1'b1;
    end
    if (st.setOff) offNext = cmdLine + 1'b1;
    if (ackTake) begin
      if (aeoiReg) begin
        if (rotAeoiReg) offNext = pendLine + 1'b1;
      end else begin
        isrNext[pendLine] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskReg <= '0; isrReg <= '0; baseReg <= '0; offReg <= '0;
      nestedReg <= 1'b0; aeoiReg <= 1'b0; rotAeoiReg <= 1'b0;
      regSelReg <= 1'b0; smmReg <= 1'b0;
    end else if (st.startInit) begin
      maskReg <= '0; isrReg <= '0; baseReg <= '0; offReg <= '0;
      nestedReg <= 1'b0; aeoiReg <= 1'b0; rotAeoiReg <= 1'b0;
      regSelReg <= 1'b0; smmReg <= 1'b0;
    end else begin
      isrReg <= isrNext;
      offReg <= offNext;
      if (st.loadBase) baseReg <= wdata & BASE_MASK;
      if (st.loadMode) begin
        nestedReg <= wdata[4];
        aeoiReg   <= wdata[1];
      end
      if (st.loadMask)   maskReg    <= wdata;
      if (st.setSel)     regSelReg  <= wdata[0];
      if (st.setSmm)     smmReg     <= wdata[5];
      if (st.setRotAeoi) rotAeoiReg <= wdata[7];
    end
  end

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      if (pollArmed)      rdata = pendValid ? {1'b1, {(DATA_W-1-LINE_W){1'b0}}, pendLine} : '0;
      else if (addr)      rdata = maskReg;
      else if (regSelReg) rdata = isrReg;
      else                rdata = irqReq;
    end
  end

  assign vecOut      = baseReg | (pendValid ? DATA_W'(pendLine) : DATA_W'(LINES - 1));
  assign ackValid    = ackTake;
  assign ackLine     = pendLine;
  assign maskOut     = maskReg;
  assign isrOut      = isrReg;
  assign prioOffset  = offReg;
  assign nestedMode  = nestedReg;
  assign autoEoiMode = aeoiReg;
  assign specialMask = smmReg;

  // R2: a start word empties mask and in-service state
  a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    st.startInit |=> (isrReg == '0) && (maskReg == '0));
  // R4: a mask write holds the written byte
  a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    st.loadMask |=> maskReg == $past(wdata));
  // R7: acknowledge without auto-EOI marks the line in service
  a_r7_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ackValid && !autoEoiMode) |=> isrReg[$past(ackLine)]);
  // R9: acknowledge under auto-EOI leaves the in-service register alone
  a_r9_aeoi_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ackValid && autoEoiMode) |=> isrReg == $past(isrReg));
  // R8: spurious acknowledge changes nothing
  a_r8_spurious_still: assert property (@(posedge clk) disable iff (!rst_n)
    (st.ackReq && !pendValid) |=> $stable(isrReg) && $stable(offReg));
  // R11: specific EOI clears the named bit
  a_r11_specific_clears: assert property (@(posedge clk) disable iff (!rst_n)
    st.eoiLine |=> !isrReg[$past(wdata[LINE_W-1:0])]);
endmodule

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder
  import irq_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [LINES-1:0]  irqReq,
  input  logic              pendValid,
  input  logic [LINE_W-1:0] pendLine,
  input  logic              intAck,
  output logic [DATA_W-1:0] vecOut,
  output logic              ackValid,
  output logic [LINE_W-1:0] ackLine,
  output logic [LINES-1:0]  maskOut,
  output logic [LINES-1:0]  isrOut,
  output logic [LINE_W-1:0] prioOffset,
  output logic              nestedMode,
  output logic              autoEoiMode,
  output logic              specialMask
);
  strobe_t st;
  logic pollArmed;

  irq_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .intAck(intAck), .st(st), .pollArmed(pollArmed)
  );

  irq_cmd_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .st(st), .pollArmed(pollArmed),
    .cs(cs), .rd(rd), .addr(addr), .wdata(wdata), .irqReq(irqReq),
    .pendValid(pendValid), .pendLine(pendLine), .rdata(rdata),
    .vecOut(vecOut), .ackValid(ackValid), .ackLine(ackLine),
    .maskOut(maskOut), .isrOut(isrOut), .prioOffset(prioOffset),
    .nestedMode(nestedMode), .autoEoiMode(autoEoiMode), .specialMask(specialMask)
  );
endmodule

// File: tb/irq_cmd_decoder_tb.sv
`timescale 1ns/1ps
module irq_cmd_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, wr = 0, rd = 0, addr = 0, pendValid = 0, intAck = 0;
  logic [7:0] wdata = 0, irqReq = 8'h5A;
  logic [2:0] pendLine = 0;
  logic [7:0] rdata, vecOut, maskOut, isrOut;
  logic [2:0] ackLine, prioOffset;
  logic ackValid, nestedMode, autoEoiMode, specialMask;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irqReq(irqReq), .pendValid(pendValid),
    .pendLine(pendLine), .intAck(intAck), .vecOut(vecOut), .ackValid(ackValid),
    .ackLine(ackLine), .maskOut(maskOut), .isrOut(isrOut), .prioOffset(prioOffset),
    .nestedMode(nestedMode), .autoEoiMode(autoEoiMode), .specialMask(specialMask)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic a, logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic busRead(logic a, logic pv, logic [2:0] pl, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a; pendValid = pv; pendLine = pl;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0; pendValid = 0;
  endtask

  task automatic doAck(logic pv, logic [2:0] pl, output logic [7:0] v, output logic av);
    @(negedge clk); intAck = 1; pendValid = pv; pendLine = pl;
    #1 v = vecOut; av = ackValid;
    @(negedge clk); intAck = 0; pendValid = 0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R1 mask", maskOut, 8'h00);
    check("R1 isr", isrOut, 8'h00);
    check("R1 offset", {5'd0, prioOffset}, 8'h00);
    check("R1 modes", {5'd0, nestedMode, autoEoiMode, specialMask}, 8'h00);
    busWrite(1, 8'h3C);
    busRead(1, 0, 0, d);
    check("R1 normal mask write", d, 8'h3C);
  endtask

  task automatic testSingleNoWord4();
    logic [7:0] v; logic av;
    busWrite(0, 8'h12);
    check("R2 init clears mask", maskOut, 8'h00);
    busWrite(1, 8'h0D);
    busWrite(1, 8'h33);
    check("R3 single skips to normal", maskOut, 8'h33);
    doAck(0, 0, v, av);
    check("R3 base anded", v, 8'h0F);
  endtask

  task automatic testSingleWord4Aeoi();
    logic [7:0] v; logic av;
    busWrite(0, 8'h13);
    busWrite(1, 8'h4D);
    busWrite(1, 8'h12);
    check("R4 nested flag", {7'd0, nestedMode}, 8'h01);
    check("R4 aeoi flag", {7'd0, autoEoiMode}, 8'h01);
    busWrite(1, 8'hA5);
    check("R4 mask after setup", maskOut, 8'hA5);
    doAck(1, 3, v, av);
    check("R7 vector", v, 8'h4B);
    check("R9 aeoi isr kept", isrOut, 8'h00);
    check("R9 no rotate", {5'd0, prioOffset}, 8'h00);
    busWrite(0, 8'h80);
    doAck(1, 5, v, av);
    check("R9 rotate on aeoi", {5'd0, prioOffset}, 8'h06);
    check("R9 isr still empty", isrOut, 8'h00);
  endtask

  task automatic testCascadeWord3();
    busWrite(0, 8'h11);
    check("R2 offset cleared", {5'd0, prioOffset}, 8'h00);
    check("R2 modes cleared", {6'd0, nestedMode, autoEoiMode}, 8'h00);
    busWrite(1, 8'h27);
    busWrite(1, 8'h04);
    check("R3 third word not mask", maskOut, 8'h00);
    busWrite(1, 8'h00);
    check("R4 fourth word clears aeoi", {7'd0, autoEoiMode}, 8'h00);
    check("R4 fourth word no mask", maskOut, 8'h00);
    busWrite(1, 8'h0F);
    check("R4 normal mask", maskOut, 8'h0F);
  endtask

  task automatic testAck();
    logic [7:0] v; logic av;
    doAck(1, 3, v, av);
    check("R7 vector line3", v, 8'h23);
    check("R7 ackValid", {7'd0, av}, 8'h01);
    check("R7 isr set", isrOut, 8'h08);
    doAck(1, 5, v, av);
    check("R7 isr second", isrOut, 8'h28);
    doAck(0, 0, v, av);
    check("R8 spurious vector", v, 8'h27);
    check("R8 no ackValid", {7'd0, av}, 8'h00);
    check("R8 isr unchanged", isrOut, 8'h28);
  endtask

  task automatic testReads();
    logic [7:0] d;
    busWrite(0, 8'h0B);
    busRead(0, 0, 0, d);
    check("R6 read isr", d, 8'h28);
    busWrite(0, 8'h0A);
    busRead(0, 0, 0, d);
    check("R6 read request", d, 8'h5A);
    busWrite(0, 8'h09);
    busRead(0, 0, 0, d);
    check("R5 select kept without bit1", d, 8'h5A);
    busRead(1, 0, 0, d);
    check("R6 read mask", d, 8'h0F);
    busWrite(0, 8'h68);
    check("R5 special mask on", {7'd0, specialMask}, 8'h01);
    busWrite(0, 8'h28);
    check("R5 special mask kept", {7'd0, specialMask}, 8'h01);
    busWrite(0, 8'h48);
    check("R5 special mask off", {7'd0, specialMask}, 8'h00);
  endtask

  task automatic testEoi();
    logic [7:0] v; logic av;
    busWrite(0, 8'h20);
    check("R10 nonspecific offset0", isrOut, 8'h20);
    doAck(1, 3, v, av);
    busWrite(0, 8'hC3);
    check("R12 set offset", {5'd0, prioOffset}, 8'h04);
    busWrite(0, 8'h20);
    check("R10 nonspecific rotated", isrOut, 8'h08);
    doAck(1, 5, v, av);
    busWrite(0, 8'hA0);
    check("R10 rotate eoi isr", isrOut, 8'h08);
    check("R10 rotate eoi offset", {5'd0, prioOffset}, 8'h06);
    busWrite(0, 8'h63);
    check("R11 specific clear", isrOut, 8'h00);
    busWrite(0, 8'h20);
    check("R10 empty no effect", {5'd0, prioOffset}, 8'h06);
    doAck(1, 2, v, av);
    doAck(1, 6, v, av);
    busWrite(0, 8'hE6);
    check("R11 specific rotate isr", isrOut, 8'h04);
    check("R11 specific rotate offset", {5'd0, prioOffset}, 8'h07);
    busWrite(0, 8'h47);
    check("R12 code2 isr", isrOut, 8'h04);
    check("R12 code2 offset", {5'd0, prioOffset}, 8'h07);
  endtask

  task automatic testPoll();
    logic [7:0] d;
    busWrite(0, 8'h0C);
    busRead(0, 1, 1, d);
    check("R13 poll value", d, 8'h81);
    check("R13 poll acks", isrOut, 8'h06);
    busRead(0, 1, 4, d);
    check("R13 disarmed", d, 8'h5A);
    busWrite(0, 8'h0C);
    busRead(1, 0, 0, d);
    check("R13 poll none", d, 8'h00);
    check("R13 none isr kept", isrOut, 8'h06);
    busRead(1, 0, 0, d);
    check("R13 disarmed mask", d, 8'h0F);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testSingleNoWord4();
    testSingleWord4Aeoi();
    testCascadeWord3();
    testAck();
    testReads();
    testEoi();
    testPoll();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule